// File: doc/BRIEF.md
# Edge-Interrupt GPIO Bank Controller

This block manages one bank of up to 32 general-purpose pins, organised as four 8-bit ports. Software configures each pin as an input or an output and writes output levels through a small 32-bit register bus. It reads back either the driven value or the sampled pin level. Every input is resynchronised and watched for edges. A qualifying edge latches a sticky per-pin pending bit.

Each pin owns a 2-bit field that both enables detection and picks the edge: off, falling, rising or both. The fields are packed as one 16-bit halfword per port. Pending bits whose pin has a non-zero field are ORed into a single level interrupt toward a parent interrupt controller. Software services it by reading the pending register and writing ones to clear the bits it handled. Byte enables let software touch a single port of any register without a read-modify-write.

Top module: `gpio_edge_bank`

## Requirements
- R1: After reset the direction, output data, pending and edge-mode registers read zero, `pin_oe` is all zero and `irq_o` is low.
- R2: Word 2 (byte offset 0x08) is direction, where a 1 makes the pin an output on `pin_oe`. Word 3 (0x0C) is output data and drives `pin_o`. A read of word 3 returns the driven bit for output pins and the synchronised pin level for input pins. Direction changes only when word 2 is written.
- R3: In words 0, 2, 3 and 4, port A (pins 0–7) is at byte offset 0 (`bus_wdata[31:24]`), followed by ports B, C and D. Pin 8k+n is bit n of byte k. `bus_be[k]` enables byte offset k, and a write leaves disabled bytes unchanged.
- R4: Word 5 (0x14) holds the port A halfword in bits [31:16] and the port B halfword in [15:0]. Word 6 (0x18) holds port C in [31:16] and port D in [15:0]. Pin n of a port uses halfword bits [2n+1:2n].
- R5: The edge field encoding is 0 = off, 1 = falling, 2 = rising and 3 = both edges. A qualifying edge on a pin sets its pending bit.
- R6: Word 4 (0x10) reads the pending bits. Writing a 1 clears a bit and writing a 0 leaves it unchanged.
- R7: When a new edge and a clearing write hit the same pending bit in one cycle, the bit stays set.
- R8: `irq_o` is high exactly when some pending bit belongs to a pin whose edge field is non-zero. Setting the field to 0 masks the pin's interrupt without discarding the pending bit.
- R9: Pins at or above `NUM_PINS` read as zero in every register and never raise a pending bit.
- R10: Word 0 (0x00) is a plain read/write register, and its contents do not change pin outputs or events.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_en | input | 1 | Bus access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_word_addr | input | 3 | Word index inside the 0x1C-byte window |
| bus_be | input | 4 | Byte enables; bit k selects byte offset k |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_word_addr` |
| pin_i | input | NUM_PINS | Pin input levels (asynchronous) |
| pin_o | output | NUM_PINS | Pin output levels |
| pin_oe | output | NUM_PINS | Pin output enables |
| irq_o | output | 1 | Level interrupt to the parent controller |

## Verification
A corrupt edge-mode field or a pending bit set at the wrong moment shows up at `irq_o` and in the pending register three clock edges after the pin change. That window covers two synchroniser stages and the latch, and the bench samples at that point. A byte-lane or halfword mix-up shows at once as a wrong read-back or a wrong pin on `pin_o`. The bench therefore sweeps every edge mode on every implemented pin and writes single lanes. It also times a clearing write against the exact cycle in which a new edge is latched.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;
  localparam int BANK_PINS = 32;
  localparam int PORT_W    = 8;
  localparam int PORTS     = BANK_PINS / PORT_W;

  typedef enum logic [1:0] {
    EDGE_OFF  = 2'd0,
    EDGE_FALL = 2'd1,
    EDGE_RISE = 2'd2,
    EDGE_BOTH = 2'd3
  } edge_mode_e;

  typedef enum logic [2:0] {
    RG_PINSEL = 3'd0,
    RG_HOLE   = 3'd1,
    RG_DIR    = 3'd2,
    RG_DATA   = 3'd3,
    RG_PEND   = 3'd4,
    RG_MODEAB = 3'd5,
    RG_MODECD = 3'd6,
    RG_HOLE2  = 3'd7
  } reg_idx_e;

  // pin vector (port A in bits 7:0) to bus word (port A in bits 31:24)
  function automatic logic [31:0] pins_to_word(logic [31:0] v);
    return {v[7:0], v[15:8], v[23:16], v[31:24]};
  endfunction

  // byte at address offset k of a bus word
  function automatic logic [7:0] lane_byte(logic [31:0] w, int k);
    return w[31-8*k -: 8];
  endfunction

  function automatic logic edge_hit(logic [1:0] mode, logic rise, logic fall);
    return (mode[1] & rise) | (mode[0] & fall);
  endfunction
endpackage

// File: rtl/gpio_edge_sync.sv
module gpio_edge_sync #(
  parameter int NUM_PINS = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pin_i,
  output logic [NUM_PINS-1:0] level_o,
  output logic [NUM_PINS-1:0] rise_o,
  output logic [NUM_PINS-1:0] fall_o
);
  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    logic meta_q, sync_q, prev_q;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        meta_q <= 1'b0;
        sync_q <= 1'b0;
        prev_q <= 1'b0;
      end else begin
        meta_q <= pin_i[p];
        sync_q <= meta_q;
        prev_q <= sync_q;
      end
    end
    assign level_o[p] = sync_q;
    assign rise_o[p]  = sync_q & ~prev_q;
    assign fall_o[p]  = ~sync_q & prev_q;
  end
endmodule

// File: rtl/gpio_edge_pending.sv
module gpio_edge_pending #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] ev_i,
  input  logic [WIDTH-1:0] clr_i,
  output logic [WIDTH-1:0] pend_o
);
  logic [WIDTH-1:0] pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= (pend_q & ~clr_i) | ev_i;
  end
  assign pend_o = pend_q;

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_i != '0) |=> ((pend_q & $past(ev_i)) == $past(ev_i))); // R7
  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i != '0) |=> ((pend_q & $past(clr_i & ~ev_i)) == '0)); // R6
endmodule

// File: rtl/gpio_edge_bank.sv
module gpio_edge_bank
  import gpio_edge_pkg::*;
#(
  parameter int NUM_PINS = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_en,
  input  logic                bus_we,
  input  logic [2:0]          bus_word_addr,
  input  logic [3:0]          bus_be,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  input  logic [NUM_PINS-1:0] pin_i,
  output logic [NUM_PINS-1:0] pin_o,
  output logic [NUM_PINS-1:0] pin_oe,
  output logic                irq_o
);
  localparam logic [31:0] IMPL = 32'((64'd1 << NUM_PINS) - 64'd1);

  function automatic logic [63:0] widen2(logic [31:0] m);
    logic [63:0] r;
    for (int p = 0; p < BANK_PINS; p++) r[2*p +: 2] = {2{m[p]}};
    return r;
  endfunction
  localparam logic [63:0] IMPL2 = widen2(IMPL);

  logic [31:0] pinsel_q, dir_q, data_q;
  logic [63:0] mode_q;
  logic [NUM_PINS-1:0] lvl_n, rise_n, fall_n;
  logic [31:0] lvl, rise, fall, ev, en, clr, pend, data_view;
  logic        wr;
  reg_idx_e    idx;

  assign wr  = bus_en & bus_we;
  assign idx = reg_idx_e'(bus_word_addr);

  gpio_edge_sync #(.NUM_PINS(NUM_PINS)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i),
    .level_o(lvl_n), .rise_o(rise_n), .fall_o(fall_n)
  );

  always_comb begin
    lvl  = '0;
    rise = '0;
    fall = '0;
    lvl[NUM_PINS-1:0]  = lvl_n;
    rise[NUM_PINS-1:0] = rise_n;
    fall[NUM_PINS-1:0] = fall_n;
  end

  for (genvar p = 0; p < BANK_PINS; p++) begin : g_ev
    assign ev[p] = edge_hit(mode_q[2*p +: 2], rise[p], fall[p]);
    assign en[p] = |mode_q[2*p +: 2];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pinsel_q <= '0;
      dir_q    <= '0;
      data_q   <= '0;
      mode_q   <= '0;
    end else if (wr) begin
      for (int k = 0; k < PORTS; k++) begin
        if (bus_be[k]) begin
          case (idx)
            RG_PINSEL: pinsel_q[8*k +: 8] <= lane_byte(bus_wdata, k) & IMPL[8*k +: 8];
            RG_DIR:    dir_q[8*k +: 8]    <= lane_byte(bus_wdata, k) & IMPL[8*k +: 8];
            RG_DATA:   data_q[8*k +: 8]   <= lane_byte(bus_wdata, k) & IMPL[8*k +: 8];
            RG_MODEAB: mode_q[16*(k/2) + ((k%2 == 0) ? 8 : 0) +: 8] <=
                         lane_byte(bus_wdata, k) & IMPL2[16*(k/2) + ((k%2 == 0) ? 8 : 0) +: 8];
            RG_MODECD: mode_q[32 + 16*(k/2) + ((k%2 == 0) ? 8 : 0) +: 8] <=
                         lane_byte(bus_wdata, k) & IMPL2[32 + 16*(k/2) + ((k%2 == 0) ? 8 : 0) +: 8];
            default: ;
          endcase
        end
      end
    end
  end

  always_comb begin
    clr = '0;
    if (wr && idx == RG_PEND) begin
      for (int k = 0; k < PORTS; k++)
        if (bus_be[k]) clr[8*k +: 8] = lane_byte(bus_wdata, k);
    end
    clr = clr & IMPL;
  end

  gpio_edge_pending #(.WIDTH(BANK_PINS)) u_pend (
    .clk(clk), .rst_n(rst_n), .ev_i(ev), .clr_i(clr), .pend_o(pend)
  );

  assign irq_o     = |(pend & en);
  assign data_view = (dir_q & data_q) | (~dir_q & lvl);
  assign pin_o     = data_q[NUM_PINS-1:0];
  assign pin_oe    = dir_q[NUM_PINS-1:0];

  always_comb begin
    case (idx)
      RG_PINSEL: bus_rdata = pins_to_word(pinsel_q);
      RG_DIR:    bus_rdata = pins_to_word(dir_q);
      RG_DATA:   bus_rdata = pins_to_word(data_view);
      RG_PEND:   bus_rdata = pins_to_word(pend);
      RG_MODEAB: bus_rdata = {mode_q[15:0], mode_q[31:16]};
      RG_MODECD: bus_rdata = {mode_q[47:32], mode_q[63:48]};
      default:   bus_rdata = '0;
    endcase
  end

  AST_IRQ_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    (pend == '0) |-> !irq_o); // R8
  AST_DIR_ONLY_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && idx == RG_DIR) |=> $stable(dir_q)); // R2
  AST_UNIMPL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend | dir_q) & ~IMPL) == '0); // R9
endmodule

// File: tb/gpio_edge_bank_tb.sv
`timescale 1ns/1ps
module gpio_edge_bank_tb;
  localparam int NP = 20;
  localparam logic [31:0] IMPLV = 32'h000F_FFFF;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_en = 1'b0, bus_we = 1'b0;
  logic [2:0] bus_word_addr = '0;
  logic [3:0] bus_be = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [NP-1:0] pin_i = '0, pin_o, pin_oe;
  logic irq_o;
  int checks = 0, errors = 0;
  logic [31:0] rd;

  always #2.5 clk = ~clk;

  gpio_edge_bank #(.NUM_PINS(NP)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_word_addr(bus_word_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .pin_i(pin_i), .pin_o(pin_o), .pin_oe(pin_oe),
    .irq_o(irq_o)
  );

  // pin vector -> bus word: byte offset k holds pins 8k..8k+7
  function automatic logic [31:0] to_word(logic [31:0] v);
    logic [31:0] w = '0;
    for (int k = 0; k < 4; k++)
      for (int b = 0; b < 8; b++) w[31 - 8*k - 7 + b] = v[8*k + b];
    return w;
  endfunction

  function automatic logic [31:0] mode_word(logic [63:0] mv, int hi);
    logic [15:0] h0, h1;
    h0 = mv[32*hi +: 16];
    h1 = mv[32*hi + 16 +: 16];
    return {h0, h1};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [3:0] be, logic [31:0] d);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_word_addr = a; bus_be = be; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0; bus_be = '0;
  endtask

  task automatic rdw(logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_word_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic set_modes(logic [63:0] mv);
    wr(3'd5, 4'hF, mode_word(mv, 0));
    wr(3'd6, 4'hF, mode_word(mv, 1));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", checks, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [63:0] mv;
    logic [31:0] dv, dd, pv, exp;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rdw(3'd2, rd); check("R1 dir", rd, 0);
    rdw(3'd3, rd); check("R1 data", rd, 0);
    rdw(3'd4, rd); check("R1 pend", rd, 0);
    rdw(3'd5, rd); check("R1 modeAB", rd, 0);
    rdw(3'd6, rd); check("R1 modeCD", rd, 0);
    check("R1 oe", 32'(pin_oe), 0);
    check("R1 irq", 32'(irq_o), 0);

    // R2 direction and data view
    dv = 32'h000F_F0F0; dd = 32'h0005_5AA5; pv = 32'h000A_A00F;
    wr(3'd2, 4'hF, to_word(dv));
    wr(3'd3, 4'hF, to_word(dd));
    pin_i = pv[NP-1:0];
    settle();
    check("R2 pin_oe", 32'(pin_oe), dv);
    check("R2 pin_o", 32'(pin_o), dd);
    rdw(3'd3, rd);
    check("R2 data view", rd, to_word(((dv & dd) | (~dv & pv)) & IMPLV));

    // R3 single lane write touches only port B
    wr(3'd3, 4'b0010, 32'hFFFF_FFFF);
    check("R3 lane B", 32'(pin_o), dd | 32'h0000_FF00);
    wr(3'd2, 4'b0001, 32'h0000_0000);
    check("R3 lane A dir", 32'(pin_oe), dv & 32'hFFFF_FF00);
    wr(3'd2, 4'hF, 32'h0); wr(3'd3, 4'hF, 32'h0);
    pin_i = '0;
    settle();

    // R4 halfword layout, R9 unimplemented fields
    wr(3'd5, 4'b1100, 32'h0000_A5C3);
    rdw(3'd5, rd); check("R4 port B halfword", rd, 32'h0000_A5C3);
    wr(3'd5, 4'b0011, 32'h1E2D_0000);
    rdw(3'd5, rd); check("R4 port A halfword", rd, 32'h1E2D_A5C3);
    wr(3'd6, 4'hF, 32'hFFFF_FFFF);
    rdw(3'd6, rd); check("R9 modeCD upper pins", rd, 32'h00FF_0000);
    wr(3'd2, 4'hF, 32'hFFFF_FFFF);
    rdw(3'd2, rd); check("R9 dir upper pins", rd, to_word(IMPLV));
    wr(3'd2, 4'hF, 32'h0);

    // R5 sweep of all modes on all pins
    for (int m = 0; m < 4; m++) begin
      set_modes({32{2'(m)}});
      wr(3'd4, 4'hF, 32'hFFFF_FFFF);
      pin_i = '1; settle();
      rdw(3'd4, rd); check("R5 rise sweep", rd, (m & 2) != 0 ? to_word(IMPLV) : 0);
      check("R8 irq rise sweep", 32'(irq_o), 32'((m & 2) != 0));
      wr(3'd4, 4'hF, 32'hFFFF_FFFF);
      pin_i = '0; settle();
      rdw(3'd4, rd); check("R5 fall sweep", rd, (m & 1) != 0 ? to_word(IMPLV) : 0);
      wr(3'd4, 4'hF, 32'hFFFF_FFFF);
    end

    // R5 walking pulse with mixed modes, pin p uses mode p%4
    mv = '0;
    for (int p = 0; p < 32; p++) mv[2*p +: 2] = 2'(p % 4);
    set_modes(mv);
    for (int p = 0; p < NP; p++) begin
      wr(3'd4, 4'hF, 32'hFFFF_FFFF);
      pin_i[p] = 1'b1; settle();
      pin_i[p] = 1'b0; settle();
      rdw(3'd4, rd);
      check("R5 walking", rd, (p % 4) != 0 ? to_word(32'h1 << p) : 0);
    end
    wr(3'd4, 4'hF, 32'hFFFF_FFFF);

    // R8 masking keeps pending
    set_modes({32{2'b11}});
    pin_i[3] = 1'b1; settle(); pin_i[3] = 1'b0; settle();
    check("R8 irq on", 32'(irq_o), 1);
    set_modes(64'h0);
    check("R8 irq masked", 32'(irq_o), 0);
    rdw(3'd4, rd); check("R8 pend kept", rd, to_word(32'h8));
    set_modes({32{2'b11}});
    check("R8 irq again", 32'(irq_o), 1);
    wr(3'd4, 4'hF, 32'hFFFF_FFFF);
    check("R8 irq cleared", 32'(irq_o), 0);

    // R6 write-one-to-clear per lane
    pv = 32'h0002_0221;
    pin_i = pv[NP-1:0]; settle(); pin_i = '0; settle();
    wr(3'd4, 4'b0001, to_word(32'h1));
    rdw(3'd4, rd); check("R6 clear pin0", rd, to_word(32'h0002_0220));
    wr(3'd4, 4'hF, 32'h0);
    rdw(3'd4, rd); check("R6 zeros keep", rd, to_word(32'h0002_0220));
    wr(3'd4, 4'hF, 32'hFFFF_FFFF);
    rdw(3'd4, rd); check("R6 clear all", rd, 0);

    // R7 edge coinciding with clear wins
    pin_i[1] = 1'b1; settle(); pin_i[1] = 1'b0;
    pin_i[0] = 1'b1; settle();
    rdw(3'd4, rd); check("R7 setup", rd, to_word(32'h3));
    @(negedge clk); pin_i[0] = 1'b0;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    bus_en = 1'b1; bus_we = 1'b1; bus_word_addr = 3'd4; bus_be = 4'hF;
    bus_wdata = to_word(32'h3);
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0; bus_be = '0;
    rdw(3'd4, rd); check("R7 set wins", rd, to_word(32'h1));
    wr(3'd4, 4'hF, 32'hFFFF_FFFF);

    // R9 upper pins never pend
    wr(3'd4, 4'hF, 32'h0);
    rdw(3'd4, rd); check("R9 pend upper", rd & ~to_word(IMPLV), 0);

    // R10 pin-select is plain storage
    wr(3'd3, 4'hF, to_word(32'h0000_1234));
    wr(3'd0, 4'hF, 32'hDEAD_BEEF);
    rdw(3'd0, rd); check("R10 readback", rd, 32'hDEAD_BEEF & to_word(IMPLV));
    check("R10 pin_o untouched", 32'(pin_o), 32'h0000_1234);
    check("R10 pin_oe untouched", 32'(pin_oe), 0);
    check("R10 irq untouched", 32'(irq_o), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule